// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general-purpose registers of a 32-bit processor core, where the register seen at a given index depends on the current processor mode. Some indices point at private physical copies in certain modes. A mode switch therefore changes what a read returns without any data being copied.

The block has two registered read ports and one write port. Each port is addressed by a 4-bit architectural index. A 5-bit mode register, loaded by a one-cycle mode-write strobe, chooses which physical copies the indices reach. Index 15, the program counter, is not held here.

Physical layout: r0 to r7 have one copy each. r8 to r12 have a shared copy and a copy private to FIQ. Stack pointer and link register pairs exist for User/System, FIQ, IRQ, Supervisor, Monitor, Abort and Undefined. Hyp has a private stack pointer only. One extra slot is always zero and never written, and index 15 reaches it.

Top module: `banked_rf`

## Requirements
- R1: On synchronous reset the mode output is Supervisor (5'b10011), every stored register is zero, and both read outputs are zero.
- R2: Indices 0 to 7 reach one shared copy in every mode.
- R3: FIQ mode (5'b10001) has private copies of r8 to r12. Entering or leaving FIQ changes the values read at those indices with no write in between.
- R4: A switch between two non-FIQ modes leaves the values read at r8 to r12 unchanged.
- R5: FIQ, IRQ (10010), Supervisor (10011), Monitor (10110), Abort (10111) and Undefined (11011) each have a private r13 and r14. User (10000) and System (11111) share one pair.
- R6: Hyp mode (11010) has a private r13. Its index 14 reaches the User link register.
- R7: A mode write with value 5'b10110 selects Monitor mode from the next cycle, and the mode output shows it. The same holds for every recognised code.
- R8: A mode write with an unrecognised code is ignored, and the previous mode is kept.
- R9: When a mode write and a register write happen in the same cycle, the register write uses the old mode.
- R10: Read data is registered with one cycle of latency. A read and a write to the same location in the same cycle return the old value, and the new value is visible one cycle later.
- R11: Index 15 stores nothing: writes to it are dropped and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode-write strobe |
| mode_val | input | 5 | Requested mode code |
| cur_mode | output | 5 | Current mode |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | DATA_W | Read port A data, registered |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | DATA_W | Read port B data, registered |
| we | input | 1 | Write enable |
| w_idx | input | 4 | Write index |
| w_data | input | DATA_W | Write data |

## Verification
The bench builds the block with the default DATA_W of 32. With full-width data, distinct 16-bit tags land in each banked copy, so any wrong bank selection shows up as a mismatched value. The bench walks every recognised mode, including transitions into and out of FIQ, Hyp and Monitor. It also covers an invalid mode code, a mode write that coincides with a register write, read-during-write, and index 15.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic [4:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_MON = 5'b10110,
    M_ABT = 5'b10111,
    M_HYP = 5'b11010,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } cpu_mode_e;

  // physical slot plan
  localparam int FIQ_HI_BASE = 15;   // FIQ r8..r12 at 15..19
  localparam int BANK_BASE   = 20;   // sp/lr pairs from here
  localparam int HYP_SP      = 32;
  localparam int NULL_SLOT   = 33;   // never written, reads zero
  localparam int NPHYS       = 34;
  localparam int PHYS_W      = $clog2(NPHYS);

  typedef logic [PHYS_W-1:0] phys_t;

  function automatic logic mode_known(input logic [4:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_MON,
      M_ABT, M_HYP, M_UND, M_SYS: mode_known = 1'b1;
      default:                    mode_known = 1'b0;
    endcase
  endfunction

  // pair number within the sp/lr bank area, User/System/Hyp use the low slots
  function automatic phys_t pair_base(input cpu_mode_e m);
    case (m)
      M_FIQ:   pair_base = phys_t'(BANK_BASE + 0);
      M_IRQ:   pair_base = phys_t'(BANK_BASE + 2);
      M_SVC:   pair_base = phys_t'(BANK_BASE + 4);
      M_MON:   pair_base = phys_t'(BANK_BASE + 6);
      M_ABT:   pair_base = phys_t'(BANK_BASE + 8);
      M_UND:   pair_base = phys_t'(BANK_BASE + 10);
      default: pair_base = phys_t'(13);
    endcase
  endfunction

  function automatic phys_t sp_slot(input cpu_mode_e m);
    sp_slot = (m == M_HYP) ? phys_t'(HYP_SP) : pair_base(m);
  endfunction

  function automatic phys_t lr_slot(input cpu_mode_e m);
    lr_slot = pair_base(m) + phys_t'(1);
  endfunction

endpackage

// File: rtl/rf_mode_reg.sv
module rf_mode_reg
  import banked_rf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_wr,
  input  logic [4:0] mode_val,
  output cpu_mode_e mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_SVC;
    end else if (mode_wr && mode_known(mode_val)) begin
      mode_q <= cpu_mode_e'(mode_val);
    end
  end

  // R8
  bad_mode_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !mode_known(mode_val)) |=> $stable(mode_q));

  // R7
  mon_select_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_val == 5'b10110) |=> (mode_q == M_MON));

endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import banked_rf_pkg::*;
(
  input  logic [3:0] idx,
  input  cpu_mode_e  mode,
  output phys_t      phys
);

  always_comb begin
    phys = phys_t'(NULL_SLOT);
    if (idx < 4'd8) begin
      phys = phys_t'(idx);
    end else if (idx <= 4'd12) begin
      phys = (mode == M_FIQ) ? phys_t'(idx) + phys_t'(FIQ_HI_BASE - 8)
                             : phys_t'(idx);
    end else if (idx == 4'd13) begin
      phys = sp_slot(mode);
    end else if (idx == 4'd14) begin
      phys = lr_slot(mode);
    end
  end

  always_comb begin
    // R2
    low_shared_chk: assert (!(idx < 4'd8) || phys == phys_t'(idx));
    // R4
    hi_shared_chk: assert (!(idx >= 4'd8 && idx <= 4'd12 && mode != M_FIQ)
                           || phys == phys_t'(idx));
    // R6
    hyp_lr_chk: assert (!(idx == 4'd14 && mode == M_HYP) || phys == phys_t'(14));
  end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 34,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd_a,
  input  logic [AW-1:0]     rb,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      rd_a <= mem[ra];
      rd_b <= mem[rb];
      if (we) mem[wa] <= wd;
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we && !$past(we) && $stable(ra)) |=> $stable(rd_a));

endmodule

// File: rtl/banked_rf.sv
module banked_rf
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [4:0]        mode_val,
  output logic [4:0]        cur_mode,
  input  logic [3:0]        ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [3:0]        w_idx,
  input  logic [DATA_W-1:0] w_data
);

  localparam int NPORT = 3;   // A read, B read, write

  cpu_mode_e  mode_q;
  logic [3:0] port_idx [NPORT];
  phys_t      port_phys [NPORT];
  logic       we_eff;

  assign port_idx[0] = ra_idx;
  assign port_idx[1] = rb_idx;
  assign port_idx[2] = w_idx;

  rf_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_wr  (mode_wr),
    .mode_val (mode_val),
    .mode_q   (mode_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rf_bank_map u_map (
      .idx  (port_idx[p]),
      .mode (mode_q),
      .phys (port_phys[p])
    );
  end

  // index 15 lands on the null slot; keep it empty
  assign we_eff = we && (port_phys[2] != phys_t'(NULL_SLOT));

  rf_store #(.DATA_W(DATA_W), .DEPTH(NPHYS)) u_store (
    .clk  (clk),
    .rst  (rst),
    .ra   (port_phys[0]),
    .rd_a (ra_data),
    .rb   (port_phys[1]),
    .rd_b (rb_data),
    .we   (we_eff),
    .wa   (port_phys[2]),
    .wd   (w_data)
  );

  assign cur_mode = mode_q;

  // R11
  pc_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == 4'd15) |=> (ra_data == '0));

endmodule

// File: tb/tb_banked_rf.sv
module tb_banked_rf;

  localparam int DW = 32;
  localparam int N  = 41;
  // row: kind(2) mode(5) idx(4) val(32); kind 0 mode, 1 write, 2 read-expect
  localparam logic [42:0] TBL [N] = '{
    {2'd1,5'h00,4'd0, 32'h0100},  // 0
    {2'd1,5'h00,4'd8, 32'h0108},  // 1
    {2'd1,5'h00,4'd13,32'h5D13},  // 2
    {2'd1,5'h00,4'd14,32'h5E14},  // 3
    {2'd0,5'h11,4'd0, 32'h0},     // 4 FIQ
    {2'd2,5'h00,4'd0, 32'h0100},  // 5 R2
    {2'd2,5'h00,4'd8, 32'h0},     // 6 R3 private r8
    {2'd1,5'h00,4'd8, 32'hF108},  // 7
    {2'd1,5'h00,4'd13,32'hF113},  // 8
    {2'd2,5'h00,4'd13,32'hF113},  // 9 R5
    {2'd2,5'h00,4'd8, 32'hF108},  // 10 R3
    {2'd0,5'h16,4'd0, 32'h0},     // 11 MON
    {2'd2,5'h00,4'd8, 32'h0108},  // 12 R3 leaving FIQ
    {2'd2,5'h00,4'd13,32'h0},     // 13 R5 mon sp
    {2'd1,5'h00,4'd14,32'h3014},  // 14
    {2'd0,5'h1A,4'd0, 32'h0},     // 15 HYP
    {2'd2,5'h00,4'd14,32'h0},     // 16 R6 usr lr
    {2'd1,5'h00,4'd14,32'hAA14},  // 17
    {2'd1,5'h00,4'd13,32'hAA13},  // 18
    {2'd0,5'h10,4'd0, 32'h0},     // 19 USR
    {2'd2,5'h00,4'd14,32'hAA14},  // 20 R6
    {2'd2,5'h00,4'd13,32'h0},     // 21 R6 hyp sp private
    {2'd2,5'h00,4'd8, 32'h0108},  // 22 R4
    {2'd0,5'h1F,4'd0, 32'h0},     // 23 SYS
    {2'd2,5'h00,4'd14,32'hAA14},  // 24 R5 usr/sys shared
    {2'd0,5'h16,4'd0, 32'h0},     // 25 MON
    {2'd2,5'h00,4'd14,32'h3014},  // 26 R7 mon lr
    {2'd0,5'h13,4'd0, 32'h0},     // 27 SVC
    {2'd2,5'h00,4'd13,32'h5D13},  // 28 R5
    {2'd2,5'h00,4'd14,32'h5E14},  // 29 R5
    {2'd0,5'h12,4'd0, 32'h0},     // 30 IRQ
    {2'd2,5'h00,4'd13,32'h0},     // 31 R5
    {2'd1,5'h00,4'd13,32'h1213},  // 32
    {2'd0,5'h17,4'd0, 32'h0},     // 33 ABT
    {2'd2,5'h00,4'd13,32'h0},     // 34 R5
    {2'd0,5'h1B,4'd0, 32'h0},     // 35 UND
    {2'd2,5'h00,4'd13,32'h0},     // 36 R5
    {2'd0,5'h12,4'd0, 32'h0},     // 37 IRQ
    {2'd2,5'h00,4'd13,32'h1213},  // 38 R5
    {2'd0,5'h11,4'd0, 32'h0},     // 39 FIQ
    {2'd2,5'h00,4'd8, 32'hF108}   // 40 R3
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          mode_wr;
  logic [4:0]    mode_val;
  logic [4:0]    cur_mode;
  logic [3:0]    ra_idx, rb_idx, w_idx;
  logic [DW-1:0] ra_data, rb_data, w_data;
  logic          we;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  banked_rf #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
    .cur_mode(cur_mode), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data), .we(we), .w_idx(w_idx),
    .w_data(w_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    mode_wr = 1'b1; mode_val = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [DW-1:0] d);
    we = 1'b1; w_idx = i; w_data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i);
    ra_idx = i; rb_idx = 4'd0;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; mode_wr = 1'b0; mode_val = '0; we = 1'b0;
    w_idx = '0; w_data = '0; ra_idx = 4'd5; rb_idx = 4'd9;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 mode", DW'(cur_mode), DW'(5'b10011));
    check("R1 rd_a", ra_data, '0);
    check("R1 rd_b", rb_data, '0);
    rd(4'd5);
    check("R1 stored", ra_data, '0);

    for (int r = 0; r < N; r++) begin
      logic [1:0]  k;
      logic [4:0]  m;
      logic [3:0]  ix;
      logic [31:0] v;
      {k, m, ix, v} = TBL[r];
      if (k == 2'd0) begin
        set_mode(m);
        check($sformatf("R7 row %0d mode", r), DW'(cur_mode), DW'(m));
      end else if (k == 2'd1) begin
        wr(ix, v);
      end else begin
        rd(ix);
        check($sformatf("R2-R6 row %0d port A", r), ra_data, v);
        check($sformatf("R2 row %0d port B", r), rb_data, 32'h0100);
      end
    end

    // R8 unrecognised codes ignored
    set_mode(5'b10011);
    set_mode(5'b10101);
    check("R8 code 10101", DW'(cur_mode), DW'(5'b10011));
    set_mode(5'b00000);
    check("R8 code 00000", DW'(cur_mode), DW'(5'b10011));

    // R9 simultaneous mode write and register write
    mode_wr = 1'b1; mode_val = 5'b10110;
    we = 1'b1; w_idx = 4'd13; w_data = 32'h9999;
    @(negedge clk);
    mode_wr = 1'b0; we = 1'b0;
    check("R9 new mode", DW'(cur_mode), DW'(5'b10110));
    rd(4'd13);
    check("R9 mon sp untouched", ra_data, '0);
    set_mode(5'b10011);
    rd(4'd13);
    check("R9 svc sp written", ra_data, 32'h9999);

    // R10 read-during-write
    ra_idx = 4'd1; we = 1'b1; w_idx = 4'd1; w_data = 32'h11;
    @(negedge clk);
    we = 1'b0;
    check("R10 old value", ra_data, '0);
    @(negedge clk);
    check("R10 new value", ra_data, 32'h11);

    // R11 index 15 holds nothing
    wr(4'd15, 32'hFFFF);
    rd(4'd15);
    check("R11 read zero", ra_data, '0);
    check("R11 no corruption", rb_data, 32'h0100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule